// File: doc/BRIEF.md
# SPI Burst Register Access Slave

This block is an SPI slave that gives an external host burst access to an internal 32-bit register and memory bus. The host holds chip select low and first sends one 32-bit header word. The header carries an operation code, a 16-bit byte address and a word count. In the same chip-select window the host then sends or receives any number of 32-bit data words. The slave decodes the header and steps the address by one word for each data word. It drives a request/ready bus, and on reads it shifts the returned data back out on MISO.

The SPI pins are sampled in the system clock domain through a synchronizer. The SPI clock therefore has to be much slower than the system clock, which this block assumes. Every bus access is routed to one of three 4 KiB address regions, and each region has its own select line. An access outside all three regions never reaches the bus and sets a sticky error flag. Read data is fetched one word ahead, so a continuous SPI clock never has to wait between words.

Top module: `spi_burst_slave`

## Requirements
- R1: SPI mode 0. Words are 32 bits, most significant bit first. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge. MISO is 0 while chip select is high and during the whole header word.
- R2: Header layout: bits 31:24 are the opcode, bits 23:8 are the 16-bit byte address of the first data word, and bits 7:0 are the word count.
- R3: Opcode 0x61 is a write. Each complete data word after the header is written to the bus with bus_we=1, at the header address for the first word and then at address+4, +8 and so on. Any opcode other than 0x61 and 0x41 causes no bus access for the rest of the window.
- R4: Opcode 0x41 is a read. The data word slots after the header carry the bus read data for the header address, then address+4 and so on, in order.
- R5: A word count of 0 means 256 words.
- R6: Words beyond the count cause no bus access. On a write they are dropped. On a read they shift out as 0.
- R7: bus_sel is one-hot during a request: bit 0 for addresses 0x0000–0x0FFF, bit 1 for 0x1000–0x1FFF, bit 2 for 0x8000–0x8FFF.
- R8: An access to any other address issues no bus request. A read of it shifts out 0. acc_err goes to 1 and stays at 1 until reset.
- R9: Raising chip select in the middle of a word discards that word and writes nothing from it. The next window starts again with a header.
- R10: Once bus_req is raised, it stays high with bus_addr, bus_we and bus_wdata unchanged until the cycle in which bus_ready is seen.
- R11: During a read burst, the fetch of the next word starts when the current word begins to shift out. By the time the first data word is halfway out, two bus reads have completed for a burst of at least two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_sel | output | 3 | One-hot region select |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access complete |
| acc_err | output | 1 | Sticky unmapped-access flag |

## Verification
The hardest case to reach from the ports is the 256-word burst that a zero count encodes. The bench gets there by streaming 257 back-to-back write words in one window, then checking that exactly 256 reached the bus and that the last one landed at the header address plus 0x3FC. The prefetch is checked by counting completed bus reads partway through the first data word of a read. A chip-select drop a few bits into a word is used to show that the partial word is discarded and that the next window decodes a clean header.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 16;
  localparam int CNT_W       = 8;
  localparam int LEN_W       = CNT_W + 1;
  localparam int NUM_REGIONS = 3;
  localparam int PAGE_W      = 4;
  localparam int STEP_BYTES  = WORD_W / 8;

  localparam logic [7:0] OPC_WRITE = 8'h61;
  localparam logic [7:0] OPC_READ  = 8'h41;

  // 4 KiB page number of each region, in select-bit order
  localparam logic [PAGE_W-1:0] REGION_PAGE [NUM_REGIONS] = '{4'h0, 4'h1, 4'h8};

  typedef struct packed {
    logic [7:0]        opc;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
  } hdr_t;

  typedef enum logic [1:0] {ST_HDR, ST_WR, ST_RD, ST_SKIP} st_t;

  function automatic logic [LEN_W-1:0] burst_len(input logic [CNT_W-1:0] c);
    return (c == '0) ? LEN_W'(1 << CNT_W) : {1'b0, c};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP_BYTES);
  endfunction
endpackage

// File: rtl/spi_burst_shift.sv
module spi_burst_shift
  import spi_burst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              active,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_load,
  output logic [CW-1:0]     bit_cnt
);
  logic [SYNC_STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic sclk_s, cs_s, mosi_s, sclk_q;
  logic rise, fall;
  logic [WORD_W-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
      sclk_q <= sclk_s;
    end
  end

  assign sclk_s  = sclk_p[SYNC_STAGES-1];
  assign cs_s    = cs_p[SYNC_STAGES-1];
  assign mosi_s  = mosi_p[SYNC_STAGES-1];
  assign active  = ~cs_s;
  assign rise    = active & sclk_s & ~sclk_q;
  assign fall    = active & ~sclk_s & sclk_q;
  // falling edge at a word boundary starts the next outgoing word
  assign tx_load = fall & (bit_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      tx_sh    <= '0;
      bit_cnt  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[WORD_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(WORD_W - 1)) rx_valid <= 1'b1;
        end
        if (fall) tx_sh <= tx_load ? tx_word : {tx_sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign rx_word = rx_sh;
  assign miso    = tx_sh[WORD_W-1];
endmodule

// File: rtl/spi_burst_region.sv
module spi_burst_region
  import spi_burst_pkg::*;
(
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_REGIONS-1:0] sel,
  output logic                   hit
);
  localparam int PAGE_LSB = ADDR_W - PAGE_W;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_page
    assign sel[g] = (addr[ADDR_W-1:PAGE_LSB] == REGION_PAGE[g]);
  end

  assign hit = |sel;
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   rx_valid,
  input  logic [WORD_W-1:0]      rx_word,
  input  logic                   tx_load,
  output logic [WORD_W-1:0]      tx_word,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [WORD_W-1:0]      bus_wdata,
  output logic [NUM_REGIONS-1:0] bus_sel,
  input  logic [WORD_W-1:0]      bus_rdata,
  input  logic                   bus_ready,
  output logic                   acc_err
);
  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [LEN_W-1:0]  left;
  logic [WORD_W-1:0] rbuf;
  logic              pend, pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic [NUM_REGIONS-1:0] pend_sel;
  logic pend_hit;

  hdr_t hdr;
  logic take_hdr, wr_word, rd_next, bus_free, issue, rd_done;

  assign hdr      = hdr_t'(rx_word);
  assign take_hdr = rx_valid && (st == ST_HDR);
  assign wr_word  = rx_valid && (st == ST_WR);
  assign rd_next  = tx_load && (st == ST_RD) && (left != '0);
  assign bus_free = !bus_req || bus_ready;
  assign issue    = pend && bus_free;
  assign rd_done  = bus_req && bus_ready && !bus_we && (st == ST_RD);

  spi_burst_region u_region (
    .addr (pend_addr),
    .sel  (pend_sel),
    .hit  (pend_hit)
  );

  // header decode and burst bookkeeping
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_HDR;
      addr <= '0;
      left <= '0;
    end else if (!active) begin
      st <= ST_HDR;
    end else if (take_hdr) begin
      case (hdr.opc)
        OPC_WRITE: begin
          st   <= ST_WR;
          addr <= hdr.addr;
          left <= burst_len(hdr.cnt);
        end
        OPC_READ: begin
          st   <= ST_RD;
          addr <= step_addr(hdr.addr);
          left <= burst_len(hdr.cnt) - 1'b1;
        end
        default: st <= ST_SKIP;
      endcase
    end else if (wr_word) begin
      addr <= step_addr(addr);
      left <= left - 1'b1;
      if (left == LEN_W'(1)) st <= ST_SKIP;
    end else if (rd_next) begin
      addr <= step_addr(addr);
      left <= left - 1'b1;
    end
  end

  // one pending access slot, then the bus handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_we   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_sel   <= '0;
      acc_err   <= 1'b0;
    end else begin
      if (take_hdr && hdr.opc == OPC_READ) begin
        pend      <= 1'b1;
        pend_we   <= 1'b0;
        pend_addr <= hdr.addr;
      end else if (wr_word) begin
        pend      <= 1'b1;
        pend_we   <= 1'b1;
        pend_addr <= addr;
        pend_data <= rx_word;
      end else if (rd_next) begin
        pend      <= 1'b1;
        pend_we   <= 1'b0;
        pend_addr <= addr;
      end else if (issue) begin
        pend <= 1'b0;
      end

      if (bus_req && bus_ready) bus_req <= 1'b0;
      if (issue) begin
        if (pend_hit) begin
          bus_req   <= 1'b1;
          bus_we    <= pend_we;
          bus_addr  <= pend_addr;
          bus_wdata <= pend_data;
          bus_sel   <= pend_sel;
        end else begin
          acc_err <= 1'b1;
        end
      end
    end
  end

  // prefetch buffer: filled by a read, emptied when its word starts shifting
  always_ff @(posedge clk) begin
    if (!rst_n)        rbuf <= '0;
    else if (!active)  rbuf <= '0;
    else if (rd_done)  rbuf <= bus_rdata;
    else if (tx_load)  rbuf <= '0;
  end

  assign tx_word = rbuf;
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import spi_burst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic                   bus_req,
  output logic                   bus_we,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [WORD_W-1:0]      bus_wdata,
  output logic [NUM_REGIONS-1:0] bus_sel,
  input  logic [WORD_W-1:0]      bus_rdata,
  input  logic                   bus_ready,
  output logic                   acc_err
);
  localparam int CW = $clog2(WORD_W);

  // named internal events, also watched by the checker
  logic              xfer_active;
  logic              word_valid;
  logic [WORD_W-1:0] word_in;
  logic              word_load;
  logic [WORD_W-1:0] word_out;
  logic [CW-1:0]     bit_cnt;

  spi_burst_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .miso     (spi_miso),
    .active   (xfer_active),
    .rx_valid (word_valid),
    .rx_word  (word_in),
    .tx_word  (word_out),
    .tx_load  (word_load),
    .bit_cnt  (bit_cnt)
  );

  spi_burst_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (xfer_active),
    .rx_valid  (word_valid),
    .rx_word   (word_in),
    .tx_load   (word_load),
    .tx_word   (word_out),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_sel   (bus_sel),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .acc_err   (acc_err)
  );
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_miso,
  input logic        bus_req,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [2:0]  bus_sel,
  input logic        bus_ready,
  input logic        acc_err,
  input logic        xfer_active,
  input logic        word_valid,
  input logic [4:0]  bit_cnt
);
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> !spi_miso); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> $countones(bus_sel) == 1); // R7
  AST_REQ_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[15:12] == 4'h0 || bus_addr[15:12] == 4'h1 || bus_addr[15:12] == 4'h8)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err); // R8
  AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> bit_cnt == 5'd0 && $past(bit_cnt) == 5'd31); // R9
  AST_BITCNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |=> bit_cnt == 5'd0); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R10
endmodule

bind spi_burst_slave spi_burst_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_miso    (spi_miso),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_sel     (bus_sel),
  .bus_ready   (bus_ready),
  .acc_err     (acc_err),
  .xfer_active (xfer_active),
  .word_valid  (word_valid),
  .bit_cnt     (bit_cnt)
);

// File: tb/spi_burst_slave_tb.sv
`timescale 1ns/1ps
module spi_burst_slave_tb;
  localparam int HP = 8; // system clocks per SCLK half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic bus_req, bus_we, bus_ready, acc_err;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0] bus_sel;

  always #2.5 clk = ~clk;

  spi_burst_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sel(bus_sel),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .acc_err(acc_err)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt, rd_cnt, rd_snap, lat;
  logic clr = 1'b0;
  logic [15:0] wr_addr_log [0:15];
  logic [31:0] wr_data_log [0:15];
  logic [2:0]  wr_sel_log  [0:15];
  logic [15:0] last_wr_addr;
  logic [2:0]  last_rd_sel;
  logic [31:0] txw [0:299];
  logic [31:0] rxw [0:299];

  function automatic logic [31:0] mem_val(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  function automatic logic [31:0] mk_hdr(input logic [7:0] op, input logic [15:0] a, input logic [7:0] c);
    return {op, a, c};
  endfunction

  // bus responder: ready two cycles after the request is seen
  always @(posedge clk) begin
    if (!rst_n || clr) begin
      bus_ready <= 1'b0; lat = 0; wr_cnt = 0; rd_cnt = 0;
      bus_rdata <= '0; last_rd_sel <= '0; last_wr_addr <= '0;
    end else begin
      bus_ready <= 1'b0;
      if (bus_req && !bus_ready) begin
        if (lat == 1) begin
          lat = 0;
          bus_ready <= 1'b1;
          if (bus_we) begin
            if (wr_cnt < 16) begin
              wr_addr_log[wr_cnt] <= bus_addr;
              wr_data_log[wr_cnt] <= bus_wdata;
              wr_sel_log[wr_cnt]  <= bus_sel;
            end
            last_wr_addr <= bus_addr;
            wr_cnt = wr_cnt + 1;
          end else begin
            bus_rdata   <= mem_val(bus_addr);
            last_rd_sel <= bus_sel;
            rd_cnt = rd_cnt + 1;
          end
        end else lat = lat + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // full words, then tail_bits of word nwords, then chip select high
  task automatic spi_xfer(input int nwords, input int tail_bits);
    rd_snap = -1;
    cs_n = 1'b0;
    wait_hp();
    for (int w = 0; w < nwords; w++) begin
      for (int b = 31; b >= 0; b--) begin
        mosi = txw[w][b];
        wait_hp();
        sclk = 1'b1;
        rxw[w][b] = miso;
        if (w == 1 && b == 28) rd_snap = rd_cnt;
        wait_hp();
        sclk = 1'b0;
      end
    end
    for (int b = 31; b > 31 - tail_bits; b--) begin
      mosi = txw[nwords][b];
      wait_hp(); sclk = 1'b1; wait_hp(); sclk = 1'b0;
    end
    wait_hp();
    cs_n = 1'b1;
    repeat (6) wait_hp();
  endtask

  task automatic t_reset();
    chk("R1 miso idle after reset", {31'd0, miso}, 32'd0);
    chk("R10 no request after reset", {31'd0, bus_req}, 32'd0);
    chk("R8 error clear after reset", {31'd0, acc_err}, 32'd0);
  endtask

  task automatic t_write_burst();
    clear_log();
    txw[0] = mk_hdr(8'h61, 16'h1010, 8'd3);
    for (int i = 1; i <= 3; i++) txw[i] = 32'hC0DE0000 + 32'(i * 17);
    spi_xfer(4, 0);
    chk("R3 write count", 32'(wr_cnt), 32'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 R3 write address", {16'd0, wr_addr_log[i]}, 32'h1010 + 32'(4 * i));
      chk("R3 write data", wr_data_log[i], txw[i + 1]);
      chk("R7 region 1 select", {29'd0, wr_sel_log[i]}, 32'b010);
    end
  endtask

  task automatic t_read_burst();
    clear_log();
    txw[0] = mk_hdr(8'h41, 16'h8000, 8'd4);
    for (int i = 1; i <= 5; i++) txw[i] = 32'hFFFFFFFF;
    spi_xfer(6, 0);
    chk("R1 miso zero during header", rxw[0], 32'd0);
    for (int i = 0; i < 4; i++)
      chk("R4 read data in order", rxw[i + 1], mem_val(16'h8000 + 16'(4 * i)));
    chk("R6 read beyond count is zero", rxw[5], 32'd0);
    chk("R6 no fetch beyond count", 32'(rd_cnt), 32'd4);
    chk("R7 region 2 select", {29'd0, last_rd_sel}, 32'b100);
    chk("R11 prefetch one word ahead", 32'(rd_snap), 32'd2);
  endtask

  task automatic t_write_excess();
    clear_log();
    txw[0] = mk_hdr(8'h61, 16'h0040, 8'd2);
    txw[1] = 32'h11111111; txw[2] = 32'h22222222; txw[3] = 32'h33333333;
    spi_xfer(4, 0);
    chk("R6 extra write word dropped", 32'(wr_cnt), 32'd2);
    chk("R6 last write address", {16'd0, last_wr_addr}, 32'h0044);
  endtask

  task automatic t_region0();
    clear_log();
    txw[0] = mk_hdr(8'h61, 16'h0FFC, 8'd1);
    txw[1] = 32'h0BADF00D;
    spi_xfer(2, 0);
    chk("R7 region 0 address", {16'd0, wr_addr_log[0]}, 32'h0FFC);
    chk("R7 region 0 select", {29'd0, wr_sel_log[0]}, 32'b001);
  endtask

  task automatic t_unmapped();
    clear_log();
    chk("R8 error clear before unmapped access", {31'd0, acc_err}, 32'd0);
    txw[0] = mk_hdr(8'h61, 16'h2000, 8'd1);
    txw[1] = 32'hDEADBEEF;
    spi_xfer(2, 0);
    chk("R8 unmapped write dropped", 32'(wr_cnt), 32'd0);
    chk("R8 error set", {31'd0, acc_err}, 32'd1);
    txw[0] = mk_hdr(8'h41, 16'h4000, 8'd2);
    txw[1] = '0; txw[2] = '0;
    spi_xfer(3, 0);
    chk("R8 unmapped read word 0 zero", rxw[1], 32'd0);
    chk("R8 unmapped read word 1 zero", rxw[2], 32'd0);
    chk("R8 no bus read issued", 32'(rd_cnt), 32'd0);
    chk("R8 error stays set", {31'd0, acc_err}, 32'd1);
  endtask

  task automatic t_abort();
    clear_log();
    txw[0] = mk_hdr(8'h61, 16'h0100, 8'd4);
    txw[1] = 32'hA0A0A0A0; txw[2] = 32'h5F5F5F5F;
    spi_xfer(2, 12);
    chk("R9 partial word not written", 32'(wr_cnt), 32'd1);
    txw[0] = mk_hdr(8'h41, 16'h0104, 8'd1);
    txw[1] = '0;
    spi_xfer(2, 0);
    chk("R9 fresh header after abort", rxw[1], mem_val(16'h0104));
  endtask

  task automatic t_bad_opcode();
    clear_log();
    txw[0] = mk_hdr(8'h22, 16'h1000, 8'd1);
    txw[1] = 32'h12345678;
    spi_xfer(2, 0);
    chk("R3 unknown opcode no access", 32'(wr_cnt + rd_cnt), 32'd0);
    chk("R3 unknown opcode miso zero", rxw[1], 32'd0);
  endtask

  task automatic t_count_zero();
    clear_log();
    txw[0] = mk_hdr(8'h61, 16'h8000, 8'd0);
    for (int i = 1; i <= 257; i++) txw[i] = 32'(i);
    spi_xfer(258, 0);
    chk("R5 zero count writes 256 words", 32'(wr_cnt), 32'd256);
    chk("R5 last address of 256 burst", {16'd0, last_wr_addr}, 32'h83FC);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_write_excess();
    t_region0();
    t_bad_opcode();
    t_abort();
    t_unmapped();
    t_count_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule